// File: doc/BRIEF.md
# Streaming LCD Timing Generator

This block drives a parallel LCD-style panel. It produces a horizontal sync, a vertical sync and a data-enable. It also moves pixel data from a ready/valid streaming sink to the panel data port. Every timing value is fixed at elaboration time: the active size, the blank and front-porch intervals, the sync widths and the sync polarities. A line is counted as a blank interval, then the active pixels, then a front porch. A frame is counted in lines in the same way.

A pixel is carried either as one beat or as three consecutive narrow beats. The block clock therefore runs at one or three times the pixel rate. The sink is ready only during active beats of active lines, so it stalls through every blank and porch interval. A missing beat never stalls the timing. Its output slot is driven with zeros instead.

Frame alignment uses a start-of-packet flag. Data is passed to the panel only after a start-of-packet beat has been accepted at the very first active beat of a frame. A start-of-packet seen anywhere else inside the active area drops the alignment until the next frame start.

Top module: `lcd_sync_stream`

## Requirements
- R1: A line lasts BEATS*(H_BLANK+H_ACTIVE+H_FRONT) clocks. The horizontal sync is active for the first H_SYNC pixels of the blank interval. Its active level is high when H_POL=1 and low when H_POL=0.
- R2: A frame lasts V_BLANK+V_ACTIVE+V_FRONT lines. The vertical sync is active for the first V_SYNC lines, with polarity set by V_POL (1 = high, 0 = low). It changes level only in the clock where the horizontal sync turns active at a line start.
- R3: The data-enable is high only for pixels H_BLANK to H_BLANK+H_ACTIVE-1 of lines V_BLANK to V_BLANK+V_ACTIVE-1. It is high for all BEATS beats of each of those pixels.
- R4: The sink ready is high exactly during active beats, as a decode of the current position. Every panel output is registered, so the data-enable is high in the clock after ready is high, and only then.
- R5: The panel data is all zeros whenever the data-enable is low.
- R6: A beat that is active but arrives with valid low produces zero data in its slot. The sync and enable timing continues without stalling.
- R7: At the first active beat of a frame (row 0, column 0, beat 0), an accepted beat with the start-of-packet flag is passed through and starts alignment. If the flag is absent or valid is low there, that whole frame outputs zeros.
- R8: A start-of-packet beat accepted at any other active position ends alignment. That beat, and the rest of the frame, output zeros.
- R9: Sink inputs are ignored during blank and porch intervals. Ready is low there, and a start-of-packet flag presented there changes neither the output nor the alignment.
- R10: While reset is high, the data-enable is low, both syncs sit at their inactive level and the data is zero. After reset is released, the timing starts at line 0, pixel 0, beat 0.
- R11: BEATS may be 1 or 3. Each pixel occupies BEATS consecutive clocks, and each clock passes one DW-bit beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, BEATS times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| snk_data | input | DW | Sink beat data |
| snk_valid | input | 1 | Sink beat valid |
| snk_sop | input | 1 | Sink start-of-packet flag (first beat of a frame) |
| snk_ready | output | 1 | Sink ready, high during active beats |
| lcd_data | output | DW | Panel data beat, registered |
| lcd_de | output | 1 | Panel data-enable, registered |
| lcd_hs | output | 1 | Horizontal sync, registered, polarity H_POL |
| lcd_vs | output | 1 | Vertical sync, registered, polarity V_POL |

## Verification
A wrong beat or pixel counter moves the sync and enable edges. The horizontal sync would then start or stop one clock early or late, which shows within a single line of about BEATS*H_TOTAL clocks. A wrong line counter misplaces the vertical sync or the enable band, which shows within one frame. A stuck or wrongly set alignment flag is invisible in the timing. It shows only in the data: zeros appear where pixels were expected, or pixels leak through in a frame that should be blanked. Such a fault therefore shows at the first active beat after a start-of-packet event, and the bench compares every clock from that point on.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  // Counter width that stays legal for a count of one.
  function automatic int cw(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } lcd_tim_t;
endpackage

// File: rtl/lcd_wrap_ctr.sv
// Modulo-N counter that advances on en; wrap pulses on the final step.
module lcd_wrap_ctr #(
  parameter int N = 2,
  localparam int W = lcd_sync_pkg::cw(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = en && (cnt == W'(N - 1));

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (en)
      cnt <= wrap ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/lcd_span_decode.sv
// Decodes a position along one axis into active, sync and first-active flags.
module lcd_span_decode #(
  parameter int BLANK  = 4,
  parameter int ACTIVE = 8,
  parameter int SYNC   = 2,
  parameter int W      = 4
) (
  input  logic [W-1:0] pos,
  output logic         in_act,
  output logic         in_sync,
  output logic         at_first
);
  int p;
  assign p        = int'(pos);
  assign in_act   = (p >= BLANK) && (p < BLANK + ACTIVE);
  assign in_sync  = (p < SYNC);
  assign at_first = (p == BLANK);
endmodule

// File: rtl/lcd_sync_stream.sv
module lcd_sync_stream #(
  parameter int       DW       = 8,
  parameter int       BEATS    = 3,
  parameter int       H_ACTIVE = 4,
  parameter int       H_BLANK  = 3,
  parameter int       H_FRONT  = 2,
  parameter int       H_SYNC   = 2,
  parameter bit       H_POL    = 1'b0,
  parameter int       V_ACTIVE = 3,
  parameter int       V_BLANK  = 2,
  parameter int       V_FRONT  = 1,
  parameter int       V_SYNC   = 1,
  parameter bit       V_POL    = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] snk_data,
  input  logic          snk_valid,
  input  logic          snk_sop,
  output logic          snk_ready,
  output logic [DW-1:0] lcd_data,
  output logic          lcd_de,
  output logic          lcd_hs,
  output logic          lcd_vs
);
  import lcd_sync_pkg::*;

  localparam int H_TOTAL = H_BLANK + H_ACTIVE + H_FRONT;
  localparam int V_TOTAL = V_BLANK + V_ACTIVE + V_FRONT;
  localparam int HW      = cw(H_TOTAL);
  localparam int VW      = cw(V_TOTAL);

  logic          pix_tick;    // last beat of a pixel
  logic          beat_first;  // first beat of a pixel
  logic          line_tick;
  logic          frame_tick;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;

  // Beat sequencing: a variant per beat count.
  generate
    if (BEATS == 1) begin : g_single
      assign pix_tick   = 1'b1;
      assign beat_first = 1'b1;
    end else begin : g_multi
      localparam int BW = cw(BEATS);
      logic [BW-1:0] beat;
      lcd_wrap_ctr #(.N(BEATS)) u_beat (
        .clk (clk),
        .rst (rst),
        .en  (1'b1),
        .cnt (beat),
        .wrap(pix_tick)
      );
      assign beat_first = (beat == '0);
    end
  endgenerate

  lcd_wrap_ctr #(.N(H_TOTAL)) u_hpos (
    .clk (clk),
    .rst (rst),
    .en  (pix_tick),
    .cnt (h_pos),
    .wrap(line_tick)
  );

  lcd_wrap_ctr #(.N(V_TOTAL)) u_vpos (
    .clk (clk),
    .rst (rst),
    .en  (line_tick),
    .cnt (v_pos),
    .wrap(frame_tick)
  );

  logic h_act, h_sync, h_first;
  logic v_act, v_sync, v_first;

  lcd_span_decode #(.BLANK(H_BLANK), .ACTIVE(H_ACTIVE), .SYNC(H_SYNC), .W(HW)) u_hdec (
    .pos     (h_pos),
    .in_act  (h_act),
    .in_sync (h_sync),
    .at_first(h_first)
  );

  lcd_span_decode #(.BLANK(V_BLANK), .ACTIVE(V_ACTIVE), .SYNC(V_SYNC), .W(VW)) u_vdec (
    .pos     (v_pos),
    .in_act  (v_act),
    .in_sync (v_sync),
    .at_first(v_first)
  );

  logic act_beat, frame_start, take_beat, locked;
  lcd_tim_t tim_nxt, tim_q;

  assign act_beat    = h_act && v_act;
  assign frame_start = act_beat && h_first && v_first && beat_first;
  assign snk_ready   = act_beat;

  // A beat is forwarded only while frame alignment holds.
  assign take_beat = act_beat && snk_valid &&
                     (frame_start ? snk_sop : (locked && !snk_sop));

  always_ff @(posedge clk) begin
    if (rst)
      locked <= 1'b0;
    else if (frame_start)
      locked <= snk_valid && snk_sop;
    else if (act_beat && snk_valid && snk_sop)
      locked <= 1'b0;
  end

  assign tim_nxt.de = act_beat;
  assign tim_nxt.hs = H_POL ? h_sync : !h_sync;
  assign tim_nxt.vs = V_POL ? v_sync : !v_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      tim_q.de <= 1'b0;
      tim_q.hs <= !H_POL;
      tim_q.vs <= !V_POL;
      lcd_data <= '0;
    end else begin
      tim_q    <= tim_nxt;
      lcd_data <= take_beat ? snk_data : '0;
    end
  end

  assign lcd_de = tim_q.de;
  assign lcd_hs = tim_q.hs;
  assign lcd_vs = tim_q.vs;
endmodule

// File: rtl/lcd_sync_checker.sv
module lcd_sync_checker #(
  parameter int DW     = 8,
  parameter int BEATS  = 3,
  parameter int H_SYNC = 2,
  parameter bit H_POL  = 1'b0,
  parameter bit V_POL  = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          snk_ready,
  input logic [DW-1:0] lcd_data,
  input logic          lcd_de,
  input logic          lcd_hs,
  input logic          lcd_vs
);
  logic hs_on, vs_on;
  int   hs_run;

  assign hs_on = (lcd_hs == H_POL);
  assign vs_on = (lcd_vs == V_POL);

  always_ff @(posedge clk) begin
    if (rst)
      hs_run <= 0;
    else
      hs_run <= hs_on ? hs_run + 1 : 0;
  end

  // R1: horizontal sync never exceeds its width in clocks
  a_r1_hs_width: assert property (@(posedge clk) disable iff (rst)
    hs_on |-> hs_run < H_SYNC * BEATS);

  // R2: vertical sync moves only at a line start
  a_r2_vs_at_line_start: assert property (@(posedge clk) disable iff (rst)
    !$stable(vs_on) |-> $rose(hs_on));

  // R4: enable follows ready by one clock
  a_r4_de_after_ready: assert property (@(posedge clk) disable iff (rst)
    snk_ready |=> lcd_de);
  a_r4_no_de_without_ready: assert property (@(posedge clk) disable iff (rst)
    !snk_ready |=> !lcd_de);

  // R5: data is zero outside the enable window
  a_r5_data_zero: assert property (@(posedge clk) disable iff (rst)
    !lcd_de |-> lcd_data == '0);

  // R9: sink stalled and enable low during vertical sync
  a_r9_quiet_vsync: assert property (@(posedge clk) disable iff (rst)
    vs_on |-> (!lcd_de && !snk_ready));
endmodule

bind lcd_sync_stream lcd_sync_checker #(
  .DW(DW), .BEATS(BEATS), .H_SYNC(H_SYNC), .H_POL(H_POL), .V_POL(V_POL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .snk_ready(snk_ready),
  .lcd_data (lcd_data),
  .lcd_de   (lcd_de),
  .lcd_hs   (lcd_hs),
  .lcd_vs   (lcd_vs)
);

// File: tb/tb_lcd_sync_stream.sv
module tb_lcd_sync_stream;
  localparam int DW = 8, B = 3;
  localparam int HA = 4, HB = 3, HF = 2, HS = 2;
  localparam int VA = 3, VB = 2, VF = 1, VS = 1;
  localparam int HT = HA + HB + HF, VT = VA + VB + VF;
  localparam int FRAME = B * HT * VT;
  localparam int RUN = 6 * FRAME + 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [DW-1:0] snk_data = '0;
  logic snk_valid = 1'b0, snk_sop = 1'b0;
  logic snk_ready, lcd_de, lcd_hs, lcd_vs;
  logic [DW-1:0] lcd_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_sync_stream #(
    .DW(DW), .BEATS(B), .H_ACTIVE(HA), .H_BLANK(HB), .H_FRONT(HF), .H_SYNC(HS),
    .H_POL(1'b0), .V_ACTIVE(VA), .V_BLANK(VB), .V_FRONT(VF), .V_SYNC(VS), .V_POL(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .snk_data(snk_data), .snk_valid(snk_valid), .snk_sop(snk_sop),
    .snk_ready(snk_ready), .lcd_data(lcd_data), .lcd_de(lcd_de), .lcd_hs(lcd_hs),
    .lcd_vs(lcd_vs)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Position of the clock k cycles after reset release.
  function automatic int f_beat(int k); return k % B; endfunction
  function automatic int f_h(int k); return (k / B) % HT; endfunction
  function automatic int f_v(int k); return (k / (B * HT)) % VT; endfunction
  function automatic bit f_act(int k);
    return f_h(k) >= HB && f_h(k) < HB + HA && f_v(k) >= VB && f_v(k) < VB + VA;
  endfunction
  function automatic bit f_first(int k);
    return f_h(k) == HB && f_v(k) == VB && f_beat(k) == 0;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit lock_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset de", lcd_de, 0);
    check("R10 reset hs", lcd_hs, 1);
    check("R10 reset vs", lcd_vs, 0);
    check("R10 reset data", lcd_data, 0);
    rst = 1'b0;
    for (int k = 0; k < RUN; k++) begin
      int f;
      bit v, s, en_exp, hs_exp, vs_exp;
      logic [DW-1:0] d, d_exp;
      f = k / FRAME;
      v = 1'b1;
      s = f_first(k);
      d = DW'(k * 7 + 3);
      if (f == 1) v = (k % 7) != 0;                          // R6 gaps
      if (f == 2) s = 1'b0;                                  // R7 no frame start
      if (f == 3 && f_v(k) == VB + 1 && f_h(k) == HB + 1 && f_beat(k) == 1)
        s = 1'b1;                                            // R8 stray start
      if (f == 4 && f_first(k)) v = 1'b0;                    // R7 start not valid
      if (f == 5 && (f_h(k) == 0 || f_v(k) == 0)) s = 1'b1;  // R9 blank noise
      snk_valid = v; snk_sop = s; snk_data = d;
      check("R4 ready", snk_ready, f_act(k));
      @(posedge clk);
      @(negedge clk);
      en_exp = f_act(k);
      hs_exp = !(f_h(k) < HS);
      vs_exp = f_v(k) < VS;
      d_exp = '0;
      if (en_exp && v && (f_first(k) ? s : (lock_m && !s))) d_exp = d;
      if (en_exp) begin
        if (f_first(k)) lock_m = v && s;
        else if (v && s) lock_m = 0;
      end
      check("R1 hs", lcd_hs, hs_exp);
      check("R2 vs", lcd_vs, vs_exp);
      check("R3 de", lcd_de, en_exp);
      check(f == 1 ? "R6 data" : f == 3 ? "R8 data" : f == 5 ? "R9 data" :
            f == 0 ? "R11 data" : "R7 data", lcd_data, d_exp);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule